// File: doc/BRIEF.md
# Serial ADC Host Controller

This block drives the serial port of a two-channel successive-approximation converter from the host side. It produces the active-low chip select, a serial clock made by dividing the system clock, and the channel-select bit on the converter's data input. It also shifts in the converter's data output. A one-cycle start strobe, a channel number and a mode request start one frame. The mode request is a full conversion, a request to enter power-down or a request to enter chained mode. The converter takes these mode requests from how many serial clock falling edges pass before chip select returns high. The controller therefore ends each frame at the edge count that matches the request.

A full conversion frame returns a 10-bit sample together with the channel and mode identifier bits that the converter sends. It also returns an error flag. The flag is raised when the fixed zero padding is broken or when the channel identifier differs from the channel selected in the frame before. The controller remembers that it has put the converter to sleep. The next conversion request then runs one extra full frame to wake it and discards the data from that frame.

Top module: `adc_link_host`

## Requirements
- R1: During and after reset, chip select is high, the serial clock is high, the data-input pin is low, and busy and the result strobe are low.
- R2: The serial clock rests high. A conversion request (mode 2'b00, and 2'b11 which acts the same) drives exactly 16 serial clock falling edges while chip select is low. Each serial clock period is 2*HALF_DIV system clocks. Chip select rises together with a rising serial clock edge.
- R3: A power-down request (mode 2'b01) raises chip select after the 2nd falling edge and before a 3rd one, and produces no result strobe.
- R4: A chained-mode request (mode 2'b10) raises chip select after the 10th falling edge, at least HALF_DIV system clocks after it, and produces no result strobe.
- R5: While chip select is low, the data-input pin holds the requested channel bit without change.
- R6: The data-output bit is sampled on each rising serial clock edge, and the first bit sampled is the most significant bit of the 16-bit frame. After a conversion frame, result valid pulses for one cycle, in the same cycle that chip select goes high. The result carries frame bits [11:2] as data, bit 13 as channel and bit 12 as mode.
- R7: The error flag is set when frame bits [15:14] or [1:0] are not all zero.
- R8: The error flag is also set when frame bit 13 differs from the channel driven in the previous frame of any kind. Before the first frame after reset, that reference channel is 0.
- R9: A conversion request that follows a power-down frame first runs one full 16-edge frame with no result. After the quiet time it runs the real conversion frame, so exactly one result comes back.
- R10: Busy is high from the cycle chip select falls until 2*HALF_DIV system clocks after chip select rises. A start strobe while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start strobe, one cycle |
| cmd_chan | input | 1 | Channel for the converter to use next |
| cmd_mode | input | 2 | 00/11 convert, 01 power down, 10 chained mode |
| busy | output | 1 | Frame or quiet time in progress |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Channel-select bit to the converter |
| adc_dout | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Conversion data |
| res_chan | output | 1 | Channel identifier returned by the converter |
| res_mode | output | 1 | Mode identifier returned by the converter |
| res_err | output | 1 | Padding or channel mismatch detected |

## Verification
A model of the converter shifts out a frame built from knobs that the bench sets, and it counts falling edges per chip-select window. Conversion, power-down and chained requests are mixed with random channels and data. Edge counts, result presence and busy tail lengths separate the three ways a frame can end. Faults are injected one at a time into the leading padding, the trailing padding and the channel bit, so each error source is seen on its own. Directed runs cover the first frame after reset, the wake sequence after power-down, and a start strobe sent in the middle of a frame.

// File: rtl/adc_link_pkg.sv
`timescale 1ns/1ps
package adc_link_pkg;
  typedef enum logic [1:0] {
    MODE_CONV     = 2'b00,
    MODE_SLEEP    = 2'b01,
    MODE_CHAIN    = 2'b10,
    MODE_CONV_ALT = 2'b11
  } req_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_FRAME = 2'b01,
    PH_QUIET = 2'b10
  } phase_e;
endpackage

// File: rtl/adc_sclk_div.sv
`timescale 1ns/1ps
module adc_sclk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CW'(HALF - 1));
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq
  import adc_link_pkg::*;
#(
  parameter int FRAME_LEN   = 16,
  parameter int SLEEP_EDGES = 2,
  parameter int CHAIN_EDGES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic       cmd_chan,
  input  logic [1:0] cmd_mode,
  output logic       run,
  output logic       cs_n,
  output logic       sclk,
  output logic       din,
  output logic       sample,
  output logic       deliver,
  output logic       ref_chan
);
  localparam int EW = $clog2(FRAME_LEN + 1);

  phase_e        phase_q, phase_d;
  logic          cs_q, cs_d, sclk_q, sclk_d;
  logic [EW-1:0] fall_q, fall_d, cut_q, cut_d;
  logic          chan_q, chan_d, conv_q, conv_d, pd_q, pd_d;
  logic          dummy_q, dummy_d, wake_q, wake_d, sleep_q, sleep_d;
  logic          quiet_q, quiet_d, ref_q, ref_d;

  always_comb begin
    phase_d = phase_q;  cs_d    = cs_q;    sclk_d  = sclk_q;
    fall_d  = fall_q;   cut_d   = cut_q;   chan_d  = chan_q;
    conv_d  = conv_q;   pd_d    = pd_q;    dummy_d = dummy_q;
    wake_d  = wake_q;   sleep_d = sleep_q; quiet_d = quiet_q;
    ref_d   = ref_q;
    sample  = 1'b0;
    deliver = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (cmd_valid) begin
          phase_d = PH_FRAME;
          cs_d    = 1'b0;
          sclk_d  = 1'b1;
          fall_d  = '0;
          chan_d  = cmd_chan;
          conv_d  = 1'b0;
          pd_d    = 1'b0;
          dummy_d = 1'b0;
          wake_d  = 1'b0;
          unique case (req_mode_e'(cmd_mode))
            MODE_SLEEP: begin
              cut_d = EW'(SLEEP_EDGES);
              pd_d  = 1'b1;
            end
            MODE_CHAIN: cut_d = EW'(CHAIN_EDGES);
            default: begin
              cut_d  = EW'(FRAME_LEN);
              conv_d = 1'b1;
              if (sleep_q) begin
                dummy_d = 1'b1;
                wake_d  = 1'b1;
              end
            end
          endcase
        end
      end
      PH_FRAME: begin
        if (tick) begin
          if (sclk_q) begin
            sclk_d = 1'b0;
            fall_d = fall_q + EW'(1);
          end else begin
            sclk_d = 1'b1;
            sample = 1'b1;
            if (fall_q == cut_q) begin
              cs_d    = 1'b1;
              phase_d = PH_QUIET;
              quiet_d = 1'b0;
              ref_d   = chan_q;
              deliver = conv_q && !dummy_q;
              if (pd_q)    sleep_d = 1'b1;
              if (dummy_q) sleep_d = 1'b0;
            end
          end
        end
      end
      PH_QUIET: begin
        if (tick) begin
          if (!quiet_q) begin
            quiet_d = 1'b1;
          end else if (wake_q) begin
            phase_d = PH_FRAME;
            cs_d    = 1'b0;
            sclk_d  = 1'b1;
            fall_d  = '0;
            cut_d   = EW'(FRAME_LEN);
            dummy_d = 1'b0;
            wake_d  = 1'b0;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;  cs_q    <= 1'b1;  sclk_q  <= 1'b1;
      fall_q  <= '0;       cut_q   <= '0;    chan_q  <= 1'b0;
      conv_q  <= 1'b0;     pd_q    <= 1'b0;  dummy_q <= 1'b0;
      wake_q  <= 1'b0;     sleep_q <= 1'b0;  quiet_q <= 1'b0;
      ref_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;  cs_q    <= cs_d;    sclk_q  <= sclk_d;
      fall_q  <= fall_d;   cut_q   <= cut_d;   chan_q  <= chan_d;
      conv_q  <= conv_d;   pd_q    <= pd_d;    dummy_q <= dummy_d;
      wake_q  <= wake_d;   sleep_q <= sleep_d; quiet_q <= quiet_d;
      ref_q   <= ref_d;
    end
  end

  assign run      = (phase_q != PH_IDLE);
  assign cs_n     = cs_q;
  assign sclk     = sclk_q;
  assign din      = !cs_q && chan_q;
  assign ref_chan = ref_q;
endmodule

// File: rtl/adc_rx_parse.sv
`timescale 1ns/1ps
module adc_rx_parse #(
  parameter int DATA_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              dout,
  input  logic              deliver,
  input  logic              ref_chan,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_chan,
  output logic              res_mode,
  output logic              res_err
);
  localparam int FRAME_LEN = 2 * PAD_W + 2 + DATA_W;
  localparam int CHAN_POS  = FRAME_LEN - 1 - PAD_W;
  localparam int MODE_POS  = CHAN_POS - 1;

  logic [FRAME_LEN-2:0] sh_q, sh_d;
  logic [FRAME_LEN-1:0] word;
  logic [PAD_W-1:0]     lead, trail;
  logic                 valid_d, chan_d, mode_d, err_d;
  logic                 chan_q, mode_q, err_q, valid_q;
  logic [DATA_W-1:0]    data_d, data_q;

  always_comb begin
    word   = {sh_q, dout};
    lead   = word[FRAME_LEN-1 -: PAD_W];
    trail  = word[PAD_W-1:0];
    sh_d   = sample ? word[FRAME_LEN-2:0] : sh_q;
    valid_d = deliver;
    data_d  = data_q;
    chan_d  = chan_q;
    mode_d  = mode_q;
    err_d   = err_q;
    if (deliver) begin
      data_d = word[PAD_W +: DATA_W];
      chan_d = word[CHAN_POS];
      mode_d = word[MODE_POS];
      err_d  = (|lead) || (|trail) || (word[CHAN_POS] != ref_chan);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      chan_q  <= 1'b0;
      mode_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      chan_q  <= chan_d;
      mode_q  <= mode_d;
      err_q   <= err_d;
    end
  end

  assign res_valid = valid_q;
  assign res_data  = data_q;
  assign res_chan  = chan_q;
  assign res_mode  = mode_q;
  assign res_err   = err_q;
endmodule

// File: rtl/adc_link_host.sv
`timescale 1ns/1ps
module adc_link_host #(
  parameter int HALF_DIV    = 2,
  parameter int DATA_W      = 10,
  parameter int PAD_W       = 2,
  parameter int SLEEP_EDGES = 2,
  parameter int CHAIN_EDGES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_chan,
  input  logic [1:0]        cmd_mode,
  output logic              busy,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_din,
  input  logic              adc_dout,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_chan,
  output logic              res_mode,
  output logic              res_err
);
  localparam int FRAME_LEN = 2 * PAD_W + 2 + DATA_W;

  logic run, tick, sample, deliver, ref_chan;

  adc_sclk_div #(.HALF(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  adc_frame_seq #(
    .FRAME_LEN(FRAME_LEN), .SLEEP_EDGES(SLEEP_EDGES), .CHAIN_EDGES(CHAIN_EDGES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_mode(cmd_mode),
    .run(run), .cs_n(adc_cs_n), .sclk(adc_sclk), .din(adc_din),
    .sample(sample), .deliver(deliver), .ref_chan(ref_chan)
  );

  adc_rx_parse #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample), .dout(adc_dout),
    .deliver(deliver), .ref_chan(ref_chan),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .res_mode(res_mode), .res_err(res_err)
  );

  assign busy = run;
endmodule

// File: rtl/adc_link_host_chk.sv
`timescale 1ns/1ps
module adc_link_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic adc_din,
  input logic res_valid
);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);

  // R2
  cs_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> $rose(adc_sclk));

  // R10
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy);

  // R5
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_din));

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R6
  res_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(adc_cs_n));
endmodule

bind adc_link_host adc_link_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk), .adc_din(adc_din), .res_valid(res_valid)
);

// File: tb/sim_adc_link_host.sv
`timescale 1ns/1ps
module sim_adc_link_host;
  localparam int HALF = 2;
  localparam real TCLK = 5.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_chan = 1'b0;
  logic [1:0] cmd_mode = 2'b00;
  logic busy, cs_n, sclk, din, res_valid, res_chan, res_mode, res_err;
  logic dout = 1'b0;
  logic [9:0] res_data;

  always #2.5 clk = ~clk;

  adc_link_host #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
    .cmd_mode(cmd_mode), .busy(busy), .adc_cs_n(cs_n), .adc_sclk(sclk),
    .adc_din(din), .adc_dout(dout), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan), .res_mode(res_mode),
    .res_err(res_err)
  );

  int n_chk = 0, n_fail = 0;
  // converter model knobs
  logic [9:0] k_data = '0;
  logic [1:0] k_lead = '0, k_trail = '0;
  bit k_flip = 0, k_mbit = 0;
  // converter model state
  logic [15:0] tx_word;
  int fall_m = 0, frames = 0, last_falls = 0, n_res = 0;
  bit din_frame = 0, din_bad = 0, prev_din = 0, busy_bad = 0;
  realtime t_f1, t_f2, t_lastf, t_csr, t_bfall;
  logic [9:0] r_data;
  bit r_chan, r_mode, r_err;
  // bench reference
  bit ref_b = 0, sleep_b = 0;

  always @(negedge cs_n) begin
    fall_m    = 0;
    din_bad   = 0;
    din_frame = din;
    if (!busy) busy_bad = 1;
    tx_word   = {k_lead, prev_din ^ k_flip, k_mbit, k_data, k_trail};
  end

  always @(negedge sclk) if (!cs_n) begin
    fall_m++;
    if (fall_m == 1) t_f1 = $realtime;
    if (fall_m == 2) t_f2 = $realtime;
    t_lastf = $realtime;
    if (din !== din_frame) din_bad = 1;
    if (fall_m <= 16) dout = tx_word[16 - fall_m];
  end

  always @(posedge cs_n) begin
    t_csr = $realtime;
    frames++;
    last_falls = fall_m;
    prev_din = din_frame;
  end

  always @(negedge busy) t_bfall = $realtime;

  always @(negedge clk) if (res_valid) begin
    n_res++;
    r_data = res_data; r_chan = res_chan; r_mode = res_mode; r_err = res_err;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_falls(input logic [1:0] md);
    return (md == 2'b01) ? 2 : (md == 2'b10) ? 10 : 16;
  endfunction

  function automatic bit exp_err(input logic [1:0] ld, input logic [1:0] tr, input bit fl);
    return (ld != 0) || (tr != 0) || fl;
  endfunction

  task automatic issue(input bit ch, input logic [1:0] md);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_chan = ch; cmd_mode = md; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic run_op(input bit ch, input logic [1:0] md, input logic [9:0] dat,
                        input logic [1:0] ld, input logic [1:0] tr, input bit fl, input bit mb);
    int f0, r0;
    bit conv, wake, xch;
    conv = (md == 2'b00) || (md == 2'b11);
    wake = conv && sleep_b;
    xch  = (wake ? ch : ref_b) ^ fl;
    k_data = dat; k_lead = ld; k_trail = tr; k_flip = fl; k_mbit = mb;
    f0 = frames; r0 = n_res;
    issue(ch, md);
    // R9 / R2: number of chip-select windows
    check(frames - f0 == (wake ? 2 : 1), wake ? "R9 frame count" : "R2 frame count",
          frames - f0, wake ? 2 : 1);
    check(last_falls == exp_falls(md), md == 2'b01 ? "R3 edges" : md == 2'b10 ? "R4 edges" : "R2 edges",
          last_falls, exp_falls(md));
    check(!din_bad && din_frame == ch, "R5 din", din_frame, ch);
    check(int'((t_bfall - t_csr) / TCLK) == 2 * HALF, "R10 quiet", int'((t_bfall - t_csr) / TCLK), 2 * HALF);
    if (conv) begin
      check(int'((t_f2 - t_f1) / TCLK) == 2 * HALF, "R2 period", int'((t_f2 - t_f1) / TCLK), 2 * HALF);
      check(n_res - r0 == 1, wake ? "R9 one result" : "R6 result count", n_res - r0, 1);
      check(r_data == dat, "R6 data", r_data, dat);
      check(r_chan == xch, "R6 chan", r_chan, xch);
      check(r_mode == mb, "R6 mode", r_mode, mb);
      check(r_err == exp_err(ld, tr, fl), fl ? "R8 err" : "R7 err", r_err, exp_err(ld, tr, fl));
      sleep_b = 0;
    end else begin
      check(n_res == r0, md == 2'b01 ? "R3 no result" : "R4 no result", n_res - r0, 0);
      if (md == 2'b10)
        check(int'((t_csr - t_lastf) / TCLK) >= HALF, "R4 delay", int'((t_csr - t_lastf) / TCLK), HALF);
      if (md == 2'b01) sleep_b = 1;
    end
    ref_b = ch;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1: reset state while held
    check(cs_n === 1'b1 && sclk === 1'b1 && din === 1'b0 && busy === 1'b0 && res_valid === 1'b0,
          "R1 reset", {cs_n, sclk, din, busy, res_valid}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    frames = 0; prev_din = 0; busy_bad = 0;
    check(cs_n === 1'b1 && busy === 1'b0, "R1 after release", {cs_n, busy}, 2'b10);

    // R8: first frame compares against channel 0
    run_op(1'b1, 2'b00, 10'h2A5, 2'b00, 2'b00, 0, 0);
    run_op(1'b0, 2'b11, 10'h3FF, 2'b00, 2'b00, 0, 1);
    // R7: leading and trailing pad faults
    run_op(1'b1, 2'b00, 10'h001, 2'b10, 2'b00, 0, 0);
    run_op(1'b1, 2'b00, 10'h200, 2'b00, 2'b01, 0, 0);
    // R8: channel mismatch
    run_op(1'b0, 2'b00, 10'h155, 2'b00, 2'b00, 1, 0);
    // R3, R9: sleep then wake
    run_op(1'b1, 2'b01, 10'h000, 2'b00, 2'b00, 0, 0);
    run_op(1'b0, 2'b00, 10'h0F0, 2'b00, 2'b00, 0, 1);
    // R4: chained-mode request
    run_op(1'b1, 2'b10, 10'h000, 2'b00, 2'b00, 0, 0);

    // R10: start strobe during a frame is ignored
    begin
      int f0, r0;
      k_data = 10'h333; k_lead = 0; k_trail = 0; k_flip = 0; k_mbit = 0;
      f0 = frames; r0 = n_res;
      @(negedge clk);
      cmd_chan = 1'b0; cmd_mode = 2'b00; cmd_valid = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
      repeat (10) @(negedge clk);
      cmd_chan = 1'b1; cmd_mode = 2'b01; cmd_valid = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(frames - f0 == 1, "R10 ignored start frames", frames - f0, 1);
      check(last_falls == 16, "R10 ignored start edges", last_falls, 16);
      check(n_res - r0 == 1 && r_data == 10'h333, "R10 ignored start result", r_data, 10'h333);
      ref_b = 1'b0;
    end

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit ch, fl;
      logic [1:0] md, ld, tr;
      int sel;
      ch = 1'($urandom);
      md = 2'($urandom);
      ld = 0; tr = 0; fl = 0;
      sel = int'($urandom % 6);
      if (sel == 0) ld = 2'($urandom % 3 + 1);
      else if (sel == 1) tr = 2'($urandom % 3 + 1);
      else if (sel == 2) fl = 1;
      run_op(ch, md, 10'($urandom), ld, tr, fl, 1'($urandom));
    end

    check(!busy_bad, "R10 busy at cs fall", busy_bad, 0);
    finish_up();
  end
endmodule